// File: doc/BRIEF.md
# Per-Channel Latched Interrupt Status Unit

This unit sits beside one DMA channel and turns the channel's live event levels into an interrupt request. Each implemented event bit is sampled every clock. While its level is high, the matching bit of a sticky request register is set on the next edge. Software clears request bits by writing ones. An enable register masks the sticky bits, and the interrupt output is high whenever any masked bit remains.

Several channels may drive one wired-OR interrupt line. Software reads a detect view, which is the AND of request and enable. A zero detect value tells the handler that this channel did not raise the line. Request bits latch whether or not they are enabled, so software can poll for an event such as an abort with its interrupt masked.

The register port is plain control: a single-cycle write strobe and an independent combinational read address. No data stream crosses the block, so it has no valid/ready handshake and no back-pressure. Events are levels, not pulses. A bit whose event stays high stays latched.

Top module: `chan_irq_unit`

## Requirements
- R1: After reset, request and enable are zero, every register reads zero and the interrupt output is low.
- R2: A read at offset 0x10 returns the live event levels of the implemented bits, in the same cycle. The implemented bits are given by a parameter whose default is bit 1 (done) and bit 13 (abort). Unimplemented bits read zero.
- R3: An implemented event bit that is high at a clock edge sets its request bit, read at offset 0x14. The bit stays set after the event drops.
- R4: Writing offset 0x14 clears each request bit whose write-data bit is 1. Request bits whose write-data bit is 0 keep their value.
- R5: When an event is high on the same edge that a write of 1 clears its request bit, the bit stays set.
- R6: Offset 0x18 is a read/write enable register. Only the implemented bits store a value; the others read zero.
- R7: Offset 0x1C reads request AND enable.
- R8: The interrupt output is high exactly when the detect value is nonzero. It falls on the edge that clears or masks the last detect bit.
- R9: Writes to offset 0x10, to offset 0x1C and to unmapped offsets change no register.
- R10: A request bit latches even while its enable bit is 0. Its detect bit and the interrupt output stay low meanwhile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_level | input | DATA_W | Live event levels from the channel |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | ADDR_W | Byte offset of the write |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Byte offset of the read |
| rd_data | output | DATA_W | Combinational read data |
| irq_out | output | 1 | Interrupt request, high when any detect bit is set |

## Verification
The bench runs a long pseudo-random sweep against an arithmetic model of request, enable, detect and the interrupt output. Writes to offsets 0x14 and 0x18 are frequent, which forces many cycles where an event and a clear hit the same bit. Without set priority, events on those cycles would be lost and the model would see a request bit of 0 where it expects 1. Directed cases check three more faults. A write-zero that clears bits would empty the request register. Decoding writes to the read-only views would corrupt enable or request. Gating the latch with enable would make a masked abort invisible to polling.

// File: rtl/irq_pkg.sv
package irq_pkg;
  // Register offsets; software decodes these, so they are fixed.
  localparam int unsigned OFS_LIVE = 'h10;
  localparam int unsigned OFS_REQ  = 'h14;
  localparam int unsigned OFS_EN   = 'h18;
  localparam int unsigned OFS_DET  = 'h1C;

  // Event bit positions.
  localparam int unsigned BIT_DONE  = 1;
  localparam int unsigned BIT_ABORT = 13;

  typedef enum logic [2:0] {
    SEL_LIVE = 3'd0,
    SEL_REQ  = 3'd1,
    SEL_EN   = 3'd2,
    SEL_DET  = 3'd3,
    SEL_NONE = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/irq_addr_dec.sv
module irq_addr_dec #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0]      addr,
  output irq_pkg::reg_sel_e      sel
);
  import irq_pkg::*;

  always_comb begin
    if (addr == ADDR_W'(OFS_LIVE))     sel = SEL_LIVE;
    else if (addr == ADDR_W'(OFS_REQ)) sel = SEL_REQ;
    else if (addr == ADDR_W'(OFS_EN))  sel = SEL_EN;
    else if (addr == ADDR_W'(OFS_DET)) sel = SEL_DET;
    else                               sel = SEL_NONE;
  end
endmodule

// File: rtl/irq_bit_cell.sv
module irq_bit_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic live,
  input  logic clr,
  input  logic en_we,
  input  logic en_d,
  output logic req_q,
  output logic en_q
);
  // A live event overrides a same-cycle clear.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      req_q <= (req_q & ~clr) | live;
      if (en_we) en_q <= en_d;
    end
  end
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux #(
  parameter int unsigned DATA_W = 32
) (
  input  irq_pkg::reg_sel_e   sel,
  input  logic [DATA_W-1:0]   live,
  input  logic [DATA_W-1:0]   req,
  input  logic [DATA_W-1:0]   en,
  input  logic [DATA_W-1:0]   det,
  output logic [DATA_W-1:0]   data
);
  import irq_pkg::*;

  always_comb begin
    unique case (sel)
      SEL_LIVE: data = live;
      SEL_REQ:  data = req;
      SEL_EN:   data = en;
      SEL_DET:  data = det;
      default:  data = '0;
    endcase
  end
endmodule

// File: rtl/chan_irq_unit.sv
module chan_irq_unit #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 8,
  parameter logic [31:0] IMPL_MASK = 32'h0000_2002
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] evt_level,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_out
);
  import irq_pkg::*;

  localparam logic [DATA_W-1:0] MASK = DATA_W'(IMPL_MASK);

  reg_sel_e          wr_sel;
  reg_sel_e          rd_sel;
  logic [DATA_W-1:0] live_v;
  logic [DATA_W-1:0] clr_v;
  logic              en_we;
  logic [DATA_W-1:0] req_v;
  logic [DATA_W-1:0] en_v;
  logic [DATA_W-1:0] det_v;

  irq_addr_dec #(.ADDR_W(ADDR_W)) u_wr_dec (.addr(wr_addr), .sel(wr_sel));
  irq_addr_dec #(.ADDR_W(ADDR_W)) u_rd_dec (.addr(rd_addr), .sel(rd_sel));

  assign live_v = evt_level & MASK;
  assign clr_v  = (wr_en && wr_sel == SEL_REQ) ? wr_data : '0;
  assign en_we  = wr_en && wr_sel == SEL_EN;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (MASK[i]) begin : g_impl
      irq_bit_cell u_cell (
        .clk   (clk),
        .rst_n (rst_n),
        .live  (live_v[i]),
        .clr   (clr_v[i]),
        .en_we (en_we),
        .en_d  (wr_data[i]),
        .req_q (req_v[i]),
        .en_q  (en_v[i])
      );
    end else begin : g_tie
      assign req_v[i] = 1'b0;
      assign en_v[i]  = 1'b0;
    end
  end

  assign det_v   = req_v & en_v;
  assign irq_out = |det_v;

  irq_read_mux #(.DATA_W(DATA_W)) u_rd_mux (
    .sel  (rd_sel),
    .live (live_v),
    .req  (req_v),
    .en   (en_v),
    .det  (det_v),
    .data (rd_data)
  );
endmodule

// File: rtl/chan_irq_unit_chk.sv
module chan_irq_unit_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] live_v,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] req_v,
  input logic [DATA_W-1:0] en_v,
  input logic              irq_out
);
  logic              wr_req;
  logic              wr_enreg;
  logic [DATA_W-1:0] clear_bits;
  assign wr_req     = wr_en && (wr_addr == ADDR_W'(irq_pkg::OFS_REQ));
  assign wr_enreg   = wr_en && (wr_addr == ADDR_W'(irq_pkg::OFS_EN));
  assign clear_bits = wr_req ? wr_data : '0;

  // R1
  reset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (req_v == '0 && en_v == '0 && !irq_out));

  // R3
  latch_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((req_v & $past(live_v)) == $past(live_v)));

  // R4
  clear_only_w1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~req_v & $past(req_v) & ~$past(clear_bits)) == '0));

  // R6
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_enreg |=> $stable(en_v));

  // R8
  irq_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == ((req_v & en_v) != '0));
endmodule

bind chan_irq_unit chan_irq_unit_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .live_v  (live_v),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .req_v   (req_v),
  .en_v    (en_v),
  .irq_out (irq_out)
);

// File: tb/tb_chan_irq_unit.sv
`timescale 1ns/1ps
module tb_chan_irq_unit;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 8;
  localparam logic [31:0] M = 32'h0000_2002;
  localparam logic [7:0] A_LIVE = 8'h10, A_REQ = 8'h14, A_EN = 8'h18, A_DET = 8'h1C;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] evt_level = '0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic          irq_out;

  int n_run = 0;
  int n_fail = 0;
  logic [DW-1:0] m_req = '0, m_en = '0;

  always #2.5 clk = ~clk;

  chan_irq_unit #(.DATA_W(DW), .ADDR_W(AW), .IMPL_MASK(M)) dut (
    .clk(clk), .rst_n(rst_n), .evt_level(evt_level), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq_out(irq_out));

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input string tag, input logic [DW-1:0] exp);
    rd_addr = a;
    #0.1;
    chk(tag, rd_data, exp);
  endtask

  // One cycle: drive at negedge, update model, check after posedge.
  task automatic step(input logic [DW-1:0] ev, input logic we,
                      input logic [AW-1:0] wa, input logic [DW-1:0] wd);
    logic [DW-1:0] clr;
    @(negedge clk);
    evt_level = ev; wr_en = we; wr_addr = wa; wr_data = wd;
    clr = (we && wa == A_REQ) ? wd : '0;
    @(posedge clk);
    #0.5;
    m_req = (m_req & ~clr) | (ev & M);
    if (we && wa == A_EN) m_en = wd & M;
    wr_en = 1'b0;
  endtask

  task automatic check_all(input string pfx);
    rd_chk(A_LIVE, {pfx, " R2 live"}, evt_level & M);
    rd_chk(A_REQ,  {pfx, " R3/R4 req"}, m_req);
    rd_chk(A_EN,   {pfx, " R6 en"}, m_en);
    rd_chk(A_DET,  {pfx, " R7 det"}, m_req & m_en);
    chk({pfx, " R8 irq"}, {31'b0, irq_out}, {31'b0, (m_req & m_en) != '0});
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #0.5;
    // R1: reset state
    check_all("R1");

    // R10: abort latches with enable off; no interrupt
    step(32'h0000_2000, 1'b0, '0, '0);
    step('0, 1'b0, '0, '0);
    rd_chk(A_REQ, "R10 abort latched", 32'h0000_2000);
    chk("R10 irq low", {31'b0, irq_out}, 32'h0);
    // R4: write 0 no effect, write 1 clears
    step('0, 1'b1, A_REQ, 32'h0000_0000);
    rd_chk(A_REQ, "R4 write0 keeps", 32'h0000_2000);
    step('0, 1'b1, A_REQ, 32'h0000_2000);
    rd_chk(A_REQ, "R4 write1 clears", 32'h0);
    // R5: set beats clear
    step(32'h0000_0002, 1'b1, A_REQ, 32'hFFFF_FFFF);
    rd_chk(A_REQ, "R5 set wins", 32'h0000_0002);
    // R9: writes to read-only / unmapped offsets
    step('0, 1'b1, A_LIVE, 32'hFFFF_FFFF);
    step('0, 1'b1, A_DET, 32'hFFFF_FFFF);
    step('0, 1'b1, 8'h40, 32'hFFFF_FFFF);
    rd_chk(A_EN, "R9 en untouched", 32'h0);
    rd_chk(A_REQ, "R9 req untouched", 32'h0000_0002);
    // R6: unimplemented enable bits read zero
    step('0, 1'b1, A_EN, 32'hFFFF_FFFF);
    rd_chk(A_EN, "R6 en masked", M);
    chk("R8 irq high", {31'b0, irq_out}, 32'h1);
    // R8: masking drops the line
    step('0, 1'b1, A_EN, 32'h0);
    chk("R8 irq masked low", {31'b0, irq_out}, 32'h0);
    // R2: unimplemented live bits read zero
    step(32'hFFFF_FFFF, 1'b0, '0, '0);
    rd_chk(A_LIVE, "R2 live masked", M);

    // Sweep
    for (int c = 0; c < 4000; c++) begin
      logic [DW-1:0] ev;
      logic [AW-1:0] wa;
      logic [DW-1:0] wd;
      int k;
      ev = $urandom() & $urandom();
      k  = $urandom_range(0, 5);
      wa = (k == 0) ? A_EN : (k == 1) ? A_LIVE : (k == 2) ? A_DET : A_REQ;
      wd = $urandom();
      step(ev, ($urandom_range(0, 3) != 0), wa, wd);
      check_all("sweep");
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule